// File: doc/BRIEF.md
# Descriptor Fetch and Dispatch Controller

This block runs a batch of DMA transfers whose descriptors sit in a table in host memory. Software programs a 64-bit table base address and an entry count, then writes a doorbell. The controller first sends one command to the read engine that copies the whole table into a local descriptor FIFO. It dispatches nothing until that copy is signalled complete.

It then takes descriptors from the FIFO in order and sends each one to the read engine or the write engine, as its direction bit selects. It waits for that engine to report completion and then posts a status write toward the host. When the FIFO is empty it posts a final status write with a completion flag and returns to idle. Splitting a large transfer into bus-sized pieces is left to the engines.

Register offsets are 0x00 base low, 0x04 base high, 0x08 entry count, 0x0C doorbell and 0x10 status. A fetched descriptor is one 256-bit beat laid out as follows:
- bits 63:0: source address
- bits 127:64: destination address
- bits 145:128: length in dwords
- bits 167:160: ID
- bit 168: direction, where 1 selects the read engine and 0 selects the write engine

All other bits are reserved.

Top module: `desc_fetch_ctrl`

## Requirements
- R1: After synchronous reset, base low and base high read 0, the count reads 1, status reads 0, and no command or status request is valid.
- R2: Base low/high and count read back what was written. A count write outside 1..MAX_ENTRIES (default 128) is dropped and the old value stays.
- R3: A doorbell write (offset 0x0C, data bit 0 set) while idle raises a read-engine command in the next cycle. That command has the fetch flag set, source equal to the base, destination 0 and length equal to count×8 dwords.
- R4: Descriptor beats are accepted only between acceptance of the fetch command and the read engine's done pulse. No engine command is issued before that done pulse. Beats offered while idle are discarded.
- R5: Descriptors are dispatched in FIFO order. Direction bit 168 equal to 1 goes to the read engine and 0 goes to the write engine, carrying source, destination and length unchanged. Reserved bits are ignored.
- R6: Only one request is outstanding at a time. The next descriptor waits for the selected engine's done pulse and the acceptance of its status write. A done pulse from the other engine is ignored.
- R7: After each descriptor completes, a status write goes to base + 32×count. Its data has the descriptor ID in bits 7:0 and bit 8 clear.
- R8: Once the FIFO is empty, a final status write goes to the same address. Its data has bit 8 set and the last completed ID in bits 7:0. The controller is idle after it is accepted.
- R9: A doorbell while busy does not restart or disturb the job and sets a sticky error flag. Only reset clears that flag.
- R10: The status register reports busy in bit 0, error in bit 1 and the last completed ID in bits 15:8.
- R11: Every command and status request holds valid and its fields steady until the ready input accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| rd_cmd_valid | output | 1 | Read-engine command valid |
| rd_cmd_ready | input | 1 | Read engine accepts command |
| rd_cmd_fetch | output | 1 | Command is the table fetch into the descriptor FIFO |
| rd_cmd_src | output | 64 | Read command source address |
| rd_cmd_dst | output | 64 | Read command destination address |
| rd_cmd_len | output | 18 | Read command length in dwords |
| rd_done | input | 1 | Read engine finished its command (pulse) |
| desc_wr_valid | input | 1 | Fetched descriptor beat valid |
| desc_wr_data | input | 256 | Fetched descriptor beat |
| wr_cmd_valid | output | 1 | Write-engine command valid |
| wr_cmd_ready | input | 1 | Write engine accepts command |
| wr_cmd_src | output | 64 | Write command source address |
| wr_cmd_dst | output | 64 | Write command destination address |
| wr_cmd_len | output | 18 | Write command length in dwords |
| wr_done | input | 1 | Write engine finished its command (pulse) |
| sts_valid | output | 1 | Status write request valid |
| sts_ready | input | 1 | Status write accepted |
| sts_addr | output | 64 | Host address of the status write |
| sts_data | output | 32 | Status word: ID in 7:0, final flag in 8 |

## Verification
A sequencer stuck in the wrong state shows at the ports within one cycle of the handshake that should have moved it. The symptoms are a command on the wrong engine, a command issued before the fetch done pulse, or a status write that never comes. A damaged FIFO pointer or a lost beat appears at the next dispatch as wrong source, destination, length or ID fields, or as an early final write. A latched job base or count that goes wrong appears in the address of the first status write. A stale last-completed ID appears both in the status word and in the status register at the end of the job.

// File: rtl/dfc_pkg.sv
package dfc_pkg;

    localparam int ADDR_W      = 64;
    localparam int LEN_W       = 18;
    localparam int ID_W        = 8;
    localparam int BEAT_W      = 256;
    localparam int STS_W       = 32;
    localparam int DESC_BYTES  = 32;
    localparam int DW_PER_DESC = DESC_BYTES / 4;

    localparam logic [4:0] OFF_BASE_LO = 5'h00;
    localparam logic [4:0] OFF_BASE_HI = 5'h04;
    localparam logic [4:0] OFF_COUNT   = 5'h08;
    localparam logic [4:0] OFF_RING    = 5'h0C;
    localparam logic [4:0] OFF_STAT    = 5'h10;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [LEN_W-1:0]  len;
        logic [ID_W-1:0]   id;
        logic              to_local;
    } desc_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_FETCH_WAIT,
        S_DISPATCH,
        S_XFER_WAIT,
        S_STATUS,
        S_FINAL
    } seq_state_e;

    // Pick the used fields out of one fetched table beat.
    function automatic desc_t unpack_desc(input logic [BEAT_W-1:0] beat);
        desc_t d;
        d.src      = beat[63:0];
        d.dst      = beat[127:64];
        d.len      = beat[128 +: LEN_W];
        d.id       = beat[160 +: ID_W];
        d.to_local = beat[168];
        return d;
    endfunction

    function automatic logic [STS_W-1:0] status_word(input logic [ID_W-1:0] id,
                                                     input logic fin);
        return {{(STS_W-ID_W-1){1'b0}}, fin, id};
    endfunction

endpackage

// File: rtl/dfc_regfile.sv
module dfc_regfile
    import dfc_pkg::*;
#(
    parameter int MAX_ENTRIES = 128,
    localparam int CNT_W = $clog2(MAX_ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [4:0]        addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              busy,
    input  logic [ID_W-1:0]   last_id,
    output logic [ADDR_W-1:0] base,
    output logic [CNT_W-1:0]  count,
    output logic              start
);

    logic [31:0]      base_lo_q, base_hi_q;
    logic [CNT_W-1:0] count_q;
    logic             err_q;
    logic             ring;
    logic             count_ok;

    assign ring     = wr_en && (addr == OFF_RING) && wdata[0];
    assign start    = ring && !busy;
    assign count_ok = (wdata != 32'd0) && (wdata <= 32'(MAX_ENTRIES));

    always_ff @(posedge clk) begin
        if (rst) begin
            base_lo_q <= '0;
            base_hi_q <= '0;
            count_q   <= CNT_W'(1);
            err_q     <= 1'b0;
        end else begin
            if (wr_en && addr == OFF_BASE_LO) base_lo_q <= wdata;
            if (wr_en && addr == OFF_BASE_HI) base_hi_q <= wdata;
            if (wr_en && addr == OFF_COUNT && count_ok) count_q <= CNT_W'(wdata);
            if (ring && busy) err_q <= 1'b1;
        end
    end

    always_comb begin
        case (addr)
            OFF_BASE_LO: rdata = base_lo_q;
            OFF_BASE_HI: rdata = base_hi_q;
            OFF_COUNT:   rdata = 32'(count_q);
            OFF_STAT:    rdata = {16'd0, last_id, 6'd0, err_q, busy};
            default:     rdata = 32'd0;
        endcase
    end

    assign base  = {base_hi_q, base_lo_q};
    assign count = count_q;

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

    p_count_range_r2: assert property (@(posedge clk) disable iff (rst)
        (count_q != '0) && (count_q <= CNT_W'(MAX_ENTRIES)));

endmodule

// File: rtl/dfc_desc_fifo.sv
module dfc_desc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [LVL_W-1:0] level_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty = (level_q == '0);
    assign full  = (level_q == LVL_W'(DEPTH));
    assign head  = mem[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr_q] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            level_q  <= '0;
        end else begin
            if (push) wr_ptr_q <= bump(wr_ptr_q);
            if (pop)  rd_ptr_q <= bump(rd_ptr_q);
            case ({push, pop})
                2'b10:   level_q <= level_q + LVL_W'(1);
                2'b01:   level_q <= level_q - LVL_W'(1);
                default: level_q <= level_q;
            endcase
        end
    end

    p_push_room_r4: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);

    p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/dfc_sequencer.sv
module dfc_sequencer
    import dfc_pkg::*;
#(
    parameter int MAX_ENTRIES = 128,
    localparam int CNT_W = $clog2(MAX_ENTRIES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  count,
    input  desc_t             head,
    input  logic              head_empty,
    output logic              pop,
    output logic              fill_open,
    output logic              rd_cmd_valid,
    input  logic              rd_cmd_ready,
    output logic              rd_cmd_fetch,
    output logic [ADDR_W-1:0] rd_cmd_src,
    output logic [ADDR_W-1:0] rd_cmd_dst,
    output logic [LEN_W-1:0]  rd_cmd_len,
    input  logic              rd_done,
    output logic              wr_cmd_valid,
    input  logic              wr_cmd_ready,
    output logic [ADDR_W-1:0] wr_cmd_src,
    output logic [ADDR_W-1:0] wr_cmd_dst,
    output logic [LEN_W-1:0]  wr_cmd_len,
    input  logic              wr_done,
    output logic              sts_valid,
    input  logic              sts_ready,
    output logic [ADDR_W-1:0] sts_addr,
    output logic [STS_W-1:0]  sts_data,
    output logic              busy,
    output logic [ID_W-1:0]   last_id
);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] job_base_q;
    logic [CNT_W-1:0]  job_cnt_q;
    logic              cur_local_q;
    logic [ID_W-1:0]   cur_id_q, last_id_q;
    logic              in_fetch, in_disp, eng_done;
    logic [LEN_W-1:0]  fetch_len;

    assign in_fetch  = (state_q == S_FETCH);
    assign in_disp   = (state_q == S_DISPATCH) && !head_empty;
    assign fetch_len = LEN_W'(32'(job_cnt_q) * DW_PER_DESC);

    always_comb begin
        rd_cmd_valid = in_fetch || (in_disp && head.to_local);
        rd_cmd_fetch = in_fetch;
        rd_cmd_src   = in_fetch ? job_base_q : head.src;
        rd_cmd_dst   = in_fetch ? '0 : head.dst;
        rd_cmd_len   = in_fetch ? fetch_len : head.len;
        wr_cmd_valid = in_disp && !head.to_local;
        wr_cmd_src   = head.src;
        wr_cmd_dst   = head.dst;
        wr_cmd_len   = head.len;
        pop          = in_disp && (head.to_local ? rd_cmd_ready : wr_cmd_ready);
        sts_valid    = (state_q == S_STATUS) || (state_q == S_FINAL);
        sts_addr     = job_base_q + ADDR_W'(32'(job_cnt_q) * DESC_BYTES);
        sts_data     = status_word(last_id_q, state_q == S_FINAL);
        eng_done     = cur_local_q ? rd_done : wr_done;
    end

    assign fill_open = (state_q == S_FETCH_WAIT);
    assign busy      = (state_q != S_IDLE);
    assign last_id   = last_id_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= S_IDLE;
            job_base_q  <= '0;
            job_cnt_q   <= '0;
            cur_local_q <= 1'b0;
            cur_id_q    <= '0;
            last_id_q   <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (start) begin
                    job_base_q <= base;
                    job_cnt_q  <= count;
                    state_q    <= S_FETCH;
                end
                S_FETCH:      if (rd_cmd_ready) state_q <= S_FETCH_WAIT;
                S_FETCH_WAIT: if (rd_done)      state_q <= S_DISPATCH;
                S_DISPATCH: begin
                    if (head_empty) begin
                        state_q <= S_FINAL;
                    end else if (pop) begin
                        cur_local_q <= head.to_local;
                        cur_id_q    <= head.id;
                        state_q     <= S_XFER_WAIT;
                    end
                end
                S_XFER_WAIT: if (eng_done) begin
                    last_id_q <= cur_id_q;
                    state_q   <= S_STATUS;
                end
                S_STATUS: if (sts_ready) state_q <= S_DISPATCH;
                S_FINAL:  if (sts_ready) state_q <= S_IDLE;
                default:  state_q <= S_IDLE;
            endcase
        end
    end

    p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_cmd_valid && !rd_cmd_ready) |=>
        (rd_cmd_valid && $stable(rd_cmd_src) && $stable(rd_cmd_dst) && $stable(rd_cmd_len)));

    p_wr_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_cmd_valid && !wr_cmd_ready) |=>
        (wr_cmd_valid && $stable(wr_cmd_src) && $stable(wr_cmd_dst) && $stable(wr_cmd_len)));

    p_sts_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (sts_valid && !sts_ready) |=> (sts_valid && $stable(sts_data) && $stable(sts_addr)));

    p_single_req_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_cmd_valid, wr_cmd_valid, sts_valid}));

    p_final_empty_r8: assert property (@(posedge clk) disable iff (rst)
        (sts_valid && sts_data[ID_W]) |-> head_empty);

endmodule

// File: rtl/desc_fetch_ctrl.sv
module desc_fetch_ctrl
    import dfc_pkg::*;
#(
    parameter int MAX_ENTRIES = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [4:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              rd_cmd_valid,
    input  logic              rd_cmd_ready,
    output logic              rd_cmd_fetch,
    output logic [ADDR_W-1:0] rd_cmd_src,
    output logic [ADDR_W-1:0] rd_cmd_dst,
    output logic [LEN_W-1:0]  rd_cmd_len,
    input  logic              rd_done,
    input  logic              desc_wr_valid,
    input  logic [BEAT_W-1:0] desc_wr_data,
    output logic              wr_cmd_valid,
    input  logic              wr_cmd_ready,
    output logic [ADDR_W-1:0] wr_cmd_src,
    output logic [ADDR_W-1:0] wr_cmd_dst,
    output logic [LEN_W-1:0]  wr_cmd_len,
    input  logic              wr_done,
    output logic              sts_valid,
    input  logic              sts_ready,
    output logic [ADDR_W-1:0] sts_addr,
    output logic [STS_W-1:0]  sts_data
);

    localparam int CNT_W  = $clog2(MAX_ENTRIES + 1);
    localparam int DESC_W = $bits(desc_t);

    logic [ADDR_W-1:0] base;
    logic [CNT_W-1:0]  count;
    logic              start, busy, pop, fill_open, push, fifo_empty, fifo_full;
    logic [ID_W-1:0]   last_id;
    desc_t             in_desc, head;
    logic [DESC_W-1:0] head_bits;

    assign in_desc = unpack_desc(desc_wr_data);
    assign push    = desc_wr_valid && fill_open && !fifo_full;
    assign head    = desc_t'(head_bits);

    dfc_regfile #(.MAX_ENTRIES(MAX_ENTRIES)) regs_i (
        .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .busy(busy), .last_id(last_id), .base(base),
        .count(count), .start(start)
    );

    dfc_desc_fifo #(.W(DESC_W), .DEPTH(MAX_ENTRIES)) fifo_i (
        .clk(clk), .rst(rst), .push(push), .push_data(in_desc), .pop(pop),
        .head(head_bits), .empty(fifo_empty), .full(fifo_full)
    );

    dfc_sequencer #(.MAX_ENTRIES(MAX_ENTRIES)) seq_i (
        .clk(clk), .rst(rst), .start(start), .base(base), .count(count),
        .head(head), .head_empty(fifo_empty), .pop(pop), .fill_open(fill_open),
        .rd_cmd_valid(rd_cmd_valid), .rd_cmd_ready(rd_cmd_ready),
        .rd_cmd_fetch(rd_cmd_fetch), .rd_cmd_src(rd_cmd_src),
        .rd_cmd_dst(rd_cmd_dst), .rd_cmd_len(rd_cmd_len), .rd_done(rd_done),
        .wr_cmd_valid(wr_cmd_valid), .wr_cmd_ready(wr_cmd_ready),
        .wr_cmd_src(wr_cmd_src), .wr_cmd_dst(wr_cmd_dst), .wr_cmd_len(wr_cmd_len),
        .wr_done(wr_done), .sts_valid(sts_valid), .sts_ready(sts_ready),
        .sts_addr(sts_addr), .sts_data(sts_data), .busy(busy), .last_id(last_id)
    );

endmodule

// File: tb/desc_fetch_ctrl_tb_top.sv
module desc_fetch_ctrl_tb_top;
    import dfc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int MAXN       = 128;
    localparam int WAIT_LIM   = 500;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        reg_wr = 0;
    logic [4:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic        rd_cmd_valid, rd_cmd_fetch, wr_cmd_valid, sts_valid;
    logic        rd_cmd_ready = 1, wr_cmd_ready = 1, sts_ready = 1;
    logic        rd_done = 0, wr_done = 0, desc_wr_valid = 0;
    logic [255:0] desc_wr_data = 0;
    logic [63:0] rd_cmd_src, rd_cmd_dst, wr_cmd_src, wr_cmd_dst, sts_addr;
    logic [17:0] rd_cmd_len, wr_cmd_len;
    logic [31:0] sts_data;

    desc_fetch_ctrl #(.MAX_ENTRIES(MAXN)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_cmd_valid(rd_cmd_valid), .rd_cmd_ready(rd_cmd_ready),
        .rd_cmd_fetch(rd_cmd_fetch), .rd_cmd_src(rd_cmd_src),
        .rd_cmd_dst(rd_cmd_dst), .rd_cmd_len(rd_cmd_len), .rd_done(rd_done),
        .desc_wr_valid(desc_wr_valid), .desc_wr_data(desc_wr_data),
        .wr_cmd_valid(wr_cmd_valid), .wr_cmd_ready(wr_cmd_ready),
        .wr_cmd_src(wr_cmd_src), .wr_cmd_dst(wr_cmd_dst), .wr_cmd_len(wr_cmd_len),
        .wr_done(wr_done), .sts_valid(sts_valid), .sts_ready(sts_ready),
        .sts_addr(sts_addr), .sts_data(sts_data)
    );

    int checks = 0;
    int errors = 0;

    logic [63:0] e_src [MAXN];
    logic [63:0] e_dst [MAXN];
    logic [17:0] e_len [MAXN];
    logic [7:0]  e_id  [MAXN];
    logic        e_loc [MAXN];
    logic [63:0] job_base;

    task automatic check(input string req, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [4:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    function automatic logic [255:0] make_beat(input int i);
        logic [255:0] b;
        b = '1;
        b[63:0]    = e_src[i];
        b[127:64]  = e_dst[i];
        b[145:128] = e_len[i];
        b[167:160] = e_id[i];
        b[168]     = e_loc[i];
        return b;
    endfunction

    task automatic fill_desc(input int n, input int seed, input logic [7:0] mask);
        for (int i = 0; i < n; i++) begin
            e_src[i] = {32'(seed), 32'(i * 4096)};
            e_dst[i] = {32'(seed + 256), 32'(i * 64 + 64)};
            e_len[i] = 18'(1 + i * 37 + seed * 1000);
            e_id[i]  = 8'(seed * 32 + i);
            e_loc[i] = mask[i % 8];
        end
    endtask

    task automatic setup_job(input logic [63:0] b, input int n);
        job_base = b;
        reg_write(OFF_BASE_LO, b[31:0]);
        reg_write(OFF_BASE_HI, b[63:32]);
        reg_write(OFF_COUNT, 32'(n));
    endtask

    task automatic wait_cmd();
        for (int k = 0; k < WAIT_LIM && !(rd_cmd_valid || wr_cmd_valid); k++) @(negedge clk);
    endtask

    task automatic wait_sts();
        for (int k = 0; k < WAIT_LIM && !sts_valid; k++) @(negedge clk);
    endtask

    // Accept the pending request on the engine (0 read, 1 write, 2 status);
    // under backpressure hold ready low first and check the request is held.
    task automatic accept(input int which, input bit bp);
        logic [63:0] snap_a;
        logic [63:0] snap_b;
        if (bp) begin
            snap_a = (which == 0) ? rd_cmd_src : (which == 1) ? wr_cmd_src : sts_addr;
            snap_b = (which == 0) ? 64'(rd_cmd_len) : (which == 1) ? 64'(wr_cmd_len) : 64'(sts_data);
            repeat (3) begin
                @(negedge clk);
                check("R11", "valid held", (which == 0) ? rd_cmd_valid : (which == 1) ? wr_cmd_valid : sts_valid, 1);
                check("R11", "addr held", (which == 0) ? rd_cmd_src : (which == 1) ? wr_cmd_src : sts_addr, snap_a);
                check("R11", "len/data held", (which == 0) ? 64'(rd_cmd_len) : (which == 1) ? 64'(wr_cmd_len) : 64'(sts_data), snap_b);
            end
            if (which == 0) rd_cmd_ready = 1; else if (which == 1) wr_cmd_ready = 1; else sts_ready = 1;
            @(negedge clk);
            rd_cmd_ready = 0; wr_cmd_ready = 0; sts_ready = 0;
        end else begin
            @(negedge clk);
        end
    endtask

    task automatic serve_job(input int n, input bit bp, input bit ring_mid,
                             input bit foreign, input bit exp_err);
        logic [31:0] v;
        logic [63:0] exp_sts;
        exp_sts = job_base + 64'(n * 32);
        rd_cmd_ready = !bp; wr_cmd_ready = !bp; sts_ready = !bp;
        reg_write(OFF_RING, 32'h1);
        check("R3", "fetch valid next cycle", rd_cmd_valid, 1);
        check("R3", "fetch flag", rd_cmd_fetch, 1);
        check("R3", "fetch src", rd_cmd_src, job_base);
        check("R3", "fetch dst", rd_cmd_dst, 0);
        check("R3", "fetch len", rd_cmd_len, 64'(n * 8));
        accept(0, bp);
        if (ring_mid) begin
            reg_write(OFF_RING, 32'h1);
            reg_read(OFF_STAT, v);
            check("R9", "busy+err after busy doorbell", v[1:0], 2'b11);
        end
        for (int i = 0; i < n; i++) begin
            desc_wr_valid = 1'b1;
            desc_wr_data  = make_beat(i);
            @(negedge clk);
            check("R4", "no command while filling", {rd_cmd_valid, wr_cmd_valid}, 0);
        end
        desc_wr_valid = 1'b0;
        repeat (2) begin
            @(negedge clk);
            check("R4", "no dispatch before fetch done", {rd_cmd_valid, wr_cmd_valid}, 0);
        end
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
        for (int i = 0; i < n; i++) begin
            wait_cmd();
            check("R5", "read engine selected", rd_cmd_valid, e_loc[i]);
            check("R5", "write engine selected", wr_cmd_valid, !e_loc[i]);
            if (e_loc[i]) begin
                check("R5", "rd fetch flag clear", rd_cmd_fetch, 0);
                check("R5", "rd src", rd_cmd_src, e_src[i]);
                check("R5", "rd dst", rd_cmd_dst, e_dst[i]);
                check("R5", "rd len", rd_cmd_len, e_len[i]);
            end else begin
                check("R5", "wr src", wr_cmd_src, e_src[i]);
                check("R5", "wr dst", wr_cmd_dst, e_dst[i]);
                check("R5", "wr len", wr_cmd_len, e_len[i]);
            end
            accept(e_loc[i] ? 0 : 1, bp);
            if (foreign) begin
                if (e_loc[i]) wr_done = 1'b1; else rd_done = 1'b1;
                @(negedge clk);
                wr_done = 1'b0; rd_done = 1'b0;
                repeat (2) begin
                    @(negedge clk);
                    check("R6", "other engine done ignored", {sts_valid, rd_cmd_valid, wr_cmd_valid}, 0);
                end
            end else begin
                check("R6", "nothing before done", {sts_valid, rd_cmd_valid, wr_cmd_valid}, 0);
            end
            if (e_loc[i]) rd_done = 1'b1; else wr_done = 1'b1;
            @(negedge clk);
            rd_done = 1'b0; wr_done = 1'b0;
            wait_sts();
            check("R7", "status valid", sts_valid, 1);
            check("R7", "status addr", sts_addr, exp_sts);
            check("R7", "status data", sts_data, {23'd0, 1'b0, e_id[i]});
            check("R6", "no command beside status", {rd_cmd_valid, wr_cmd_valid}, 0);
            accept(2, bp);
        end
        wait_sts();
        check("R8", "final valid", sts_valid, 1);
        check("R8", "final addr", sts_addr, exp_sts);
        check("R8", "final data", sts_data, {23'd0, 1'b1, (n > 0) ? e_id[n-1] : 8'd0});
        accept(2, bp);
        reg_read(OFF_STAT, v);
        check("R10", "status idle/err", v[1:0], {exp_err, 1'b0});
        check("R10", "status last id", v[15:8], e_id[n-1]);
        check("R8", "idle outputs", {rd_cmd_valid, wr_cmd_valid, sts_valid}, 0);
        rd_cmd_ready = 1; wr_cmd_ready = 1; sts_ready = 1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        do_reset();
        reg_read(OFF_BASE_LO, v); check("R1", "base lo", v, 0);
        reg_read(OFF_BASE_HI, v); check("R1", "base hi", v, 0);
        reg_read(OFF_COUNT, v);   check("R1", "count", v, 1);
        reg_read(OFF_STAT, v);    check("R1", "status", v, 0);
        check("R1", "no requests", {rd_cmd_valid, wr_cmd_valid, sts_valid}, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        reg_write(OFF_BASE_LO, 32'hDEAD_BEE0);
        reg_write(OFF_BASE_HI, 32'h0000_00A5);
        reg_write(OFF_COUNT, 32'd3);
        reg_read(OFF_BASE_LO, v); check("R2", "base lo readback", v, 32'hDEAD_BEE0);
        reg_read(OFF_BASE_HI, v); check("R2", "base hi readback", v, 32'h0000_00A5);
        reg_read(OFF_COUNT, v);   check("R2", "count readback", v, 3);
        reg_write(OFF_COUNT, 32'd0);
        reg_read(OFF_COUNT, v);   check("R2", "count 0 dropped", v, 3);
        reg_write(OFF_COUNT, 32'd129);
        reg_read(OFF_COUNT, v);   check("R2", "count 129 dropped", v, 3);
        reg_write(OFF_COUNT, 32'd128);
        reg_read(OFF_COUNT, v);   check("R2", "count 128 kept", v, 128);
        reg_read(OFF_STAT, v);    check("R2", "no start without doorbell", v[0], 0);
    endtask

    task automatic t_mixed_job();
        fill_desc(3, 1, 8'b0000_0101);
        setup_job(64'h0000_0002_1000_0000, 3);
        serve_job(3, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_backpressure_job();
        fill_desc(4, 2, 8'b0000_0110);
        setup_job(64'h0000_0000_0040_0020, 4);
        serve_job(4, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_stray_push_job();
        desc_wr_valid = 1'b1;
        desc_wr_data  = '0;
        desc_wr_data[167:160] = 8'hEE;
        repeat (2) @(negedge clk);
        desc_wr_valid = 1'b0;
        fill_desc(2, 3, 8'b0000_0010);
        setup_job(64'h0000_0011_0000_1000, 2);
        serve_job(2, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_busy_doorbell();
        logic [31:0] v;
        fill_desc(1, 4, 8'b0000_0001);
        setup_job(64'h0000_0000_8000_0000, 1);
        serve_job(1, 1'b0, 1'b1, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        reg_read(OFF_STAT, v);
        check("R9", "error sticky while idle", v[1], 1);
        check("R9", "no restart", {rd_cmd_valid, wr_cmd_valid, sts_valid}, 0);
        do_reset();
        reg_read(OFF_STAT, v);
        check("R9", "reset clears error", v[1], 0);
    endtask

    task automatic t_full_table();
        fill_desc(MAXN, 5, 8'b1001_0110);
        setup_job(64'h0000_0003_0000_0000, MAXN);
        serve_job(MAXN, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got hung run expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_regs();
        t_mixed_job();
        t_backpressure_job();
        t_stray_push_job();
        t_busy_doorbell();
        t_full_table();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule